// File: doc/BRIEF.md
# Dual-Core Level Interrupt Router

This block gathers 128 level-sensitive interrupt lines and presents them to two processor cores through a small 32-bit register port. Every core owns a private bank of eight words. The first four words hold that core's enable masks, which software can read and write. The next four words hold the synchronized levels of the sources, which software can only read. Software on a core finds its work by ANDing a status word with the matching enable word.

Within a bank the words run in reverse order. Word 0 covers the highest-numbered sources and word 3 covers sources 0 to 31. Each enable word is a single plain register that software rewrites as a whole, so there are no separate set-bit or clear-bit registers. Each core has one registered interrupt output. It is high when any source is both active and enabled in that core's bank. The two banks are independent, so a source enabled in both banks reaches both cores in the same cycle.

Top module: `irq_router_top`

## Requirements
- R1: The register window is 16 words at byte offsets 0x00 to 0x3C. Core 0's bank starts at 0x00 and core 1's bank at 0x20. Inside a bank, offsets +0x00, +0x04, +0x08 and +0x0C are enable words 0 to 3, and offsets +0x10 to +0x1C are status words 0 to 3. Address bits [1:0] are ignored.
- R2: Bit b of enable or status word w maps to source number (3-w)*32+b. Word 0 holds sources 96 to 127 and word 3 holds sources 0 to 31.
- R3: Synchronous active-low reset clears every enable bit in both banks and drives both core outputs low.
- R4: A status bit shows its source level after a two-flop synchronizer. A level applied just after a clock edge becomes visible in a status read after the second following edge, and is not visible after the first.
- R5: core_irq[c] is a register that holds the OR over all four words of (status AND core c's enable).
- R6: An enable word stores the whole 32-bit value written to it and reads it back unchanged.
- R7: The two banks are independent. A write to one bank's enables never changes the other bank. A source enabled in both banks raises both outputs in the same cycle.
- R8: Writes to status offsets are ignored. Enables and status reads are left unchanged.
- R9: Reads of byte addresses from 0x40 upward return zero, and writes there change nothing.
- R10: An enable write captured at clock edge k shows on core_irq at edge k+1 and not earlier.
- R11: Register reads are combinational. reg_rdata reflects reg_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 128 | Asynchronous level interrupt sources, bit n is source n |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, captured at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| core_irq | output | 2 | Per-core interrupt request, bit c for core c |

## Verification
The bench places sources at word seams (31/32, 95/96/97, 126/127) and enables neighbours that must not match. A design with the word order or bit slicing swapped raises the wrong core or reads the wrong status word. Writes are aimed at status offsets and at addresses past the window whose low bits alias a real bank. A decoder that drops the window or status check would then corrupt an enable word or return non-zero data. Timing is probed edge by edge: status must appear after exactly two edges, and an enable write must reach the output one edge after it is captured. An extra or missing register stage fails those checks. Both cores are enabled for one source to show they are signalled together.

// File: rtl/irq_rt_pkg.sv
// Shared constants and types for the dual-core interrupt router.
// Assumes 32-bit register words throughout.
package irq_rt_pkg;
    localparam int WORD_W = 32;

    // Kind of register selected by the current address
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ENABLE = 2'd1,
        ACC_STATUS = 2'd2
    } acc_e;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer for a vector of independent level signals.
// Assumes every bit is a slow level whose individual bits may be
// sampled in different cycles; no cross-bit coherency is promised.
module irq_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] hold_q;

    // Two sampling stages, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= async_in;
            hold_q <= meta_q;
        end
    end

    assign sync_out = hold_q;
endmodule

// File: rtl/irq_addr_decode.sv
// Turns a byte address into (kind, core, word) for the packed banks.
// Each core owns 2*N_WORDS consecutive words: enables first, then status.
// Addresses beyond N_CORES banks decode to ACC_NONE. Bits [1:0] ignored.
module irq_addr_decode
    import irq_rt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_CORES = 2,
    parameter int N_WORDS = 4,
    parameter int CORE_W  = 1,
    parameter int WSEL_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc,
    output logic [CORE_W-1:0] core,
    output logic [WSEL_W-1:0] word
);
    localparam int unsigned BANK_WORDS  = 2 * N_WORDS;
    localparam int unsigned TOTAL_WORDS = N_CORES * BANK_WORDS;
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Window check and split of the word index into bank and offset
    always_comb begin
        int unsigned idx_u;
        int unsigned off_u;
        idx_u = 32'(idx);
        off_u = 0;
        acc   = ACC_NONE;
        core  = '0;
        word  = '0;
        if (idx_u < TOTAL_WORDS) begin
            off_u = idx_u % BANK_WORDS;
            core  = CORE_W'(idx_u / BANK_WORDS);
            word  = WSEL_W'(off_u % N_WORDS);
            acc   = (off_u >= N_WORDS) ? ACC_STATUS : ACC_ENABLE;
        end
    end
endmodule

// File: rtl/irq_core_bank.sv
// One core's enable storage and interrupt reduction.
// Register word w covers sources (N_WORDS-1-w)*WORD_W upward (reversed).
// status_flat and en_flat are in source order (bit n = source n).
// The output is registered: one edge after enables or status change.
module irq_core_bank #(
    parameter int N_WORDS = 4,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WSEL_W-1:0]         wr_word,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [N_WORDS*WORD_W-1:0] status_flat,
    input  logic [WSEL_W-1:0]         rd_word,
    output logic [WORD_W-1:0]         rd_data,
    output logic [N_WORDS*WORD_W-1:0] en_flat,
    output logic                      irq
);
    logic [WORD_W-1:0]  en_q [N_WORDS];
    logic [N_WORDS-1:0] word_hit;
    logic               irq_q;

    // Whole-word enable writes, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < N_WORDS; w++) en_q[w] <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < N_WORDS; w++)
                if (wr_word == WSEL_W'(w)) en_q[w] <= wr_data;
        end
    end

    // Per-word pending detection and flattening in source order
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        localparam int BASE = (N_WORDS - 1 - w) * WORD_W;
        assign en_flat[BASE +: WORD_W] = en_q[w];
        assign word_hit[w] = |(en_q[w] & status_flat[BASE +: WORD_W]);
    end

    // Registered OR reduction of all pending words
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |word_hit;
    end

    // Read port for the addressed enable word
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < N_WORDS; w++)
            if (rd_word == WSEL_W'(w)) rd_data = en_q[w];
    end

    assign irq = irq_q;
endmodule

// File: rtl/irq_router_top.sv
// Dual-core level interrupt router with packed per-core register banks.
// Assumes a simple single-cycle register port: writes are captured at
// the rising edge when reg_we is high, reads are combinational.
module irq_router_top
    import irq_rt_pkg::*;
#(
    parameter int N_CORES = 2,
    parameter int N_WORDS = 4,
    parameter int ADDR_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_WORDS*irq_rt_pkg::WORD_W-1:0] irq_src,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic                                 reg_we,
    input  logic [irq_rt_pkg::WORD_W-1:0]        reg_wdata,
    output logic [irq_rt_pkg::WORD_W-1:0]        reg_rdata,
    output logic [N_CORES-1:0]                   core_irq
);
    localparam int N_SRC  = N_WORDS * WORD_W;
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic [N_SRC-1:0]         stat_q;
    logic [N_CORES*N_SRC-1:0] en_all;
    logic [WORD_W-1:0]        bank_rd [N_CORES];
    logic [WORD_W-1:0]        stat_word;
    acc_e                     dec_acc;
    logic [CORE_W-1:0]        dec_core;
    logic [WSEL_W-1:0]        dec_word;

    irq_sync #(.WIDTH(N_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_src),
        .sync_out (stat_q)
    );

    irq_addr_decode #(
        .ADDR_W  (ADDR_W),
        .N_CORES (N_CORES),
        .N_WORDS (N_WORDS),
        .CORE_W  (CORE_W),
        .WSEL_W  (WSEL_W)
    ) u_dec (
        .addr (reg_addr),
        .acc  (dec_acc),
        .core (dec_core),
        .word (dec_word)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic bank_we;
        assign bank_we = reg_we && (dec_acc == ACC_ENABLE) && (dec_core == CORE_W'(c));

        irq_core_bank #(
            .N_WORDS (N_WORDS),
            .WORD_W  (WORD_W),
            .WSEL_W  (WSEL_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bank_we),
            .wr_word     (dec_word),
            .wr_data     (reg_wdata),
            .status_flat (stat_q),
            .rd_word     (dec_word),
            .rd_data     (bank_rd[c]),
            .en_flat     (en_all[c*N_SRC +: N_SRC]),
            .irq         (core_irq[c])
        );
    end

    // Select the status word in reversed word order
    always_comb begin
        stat_word = '0;
        for (int w = 0; w < N_WORDS; w++)
            if (dec_word == WSEL_W'(w)) stat_word = stat_q[(N_WORDS-1-w)*WORD_W +: WORD_W];
    end

    // Read data mux; unmapped addresses return zero
    always_comb begin
        case (dec_acc)
            ACC_ENABLE: reg_rdata = bank_rd[dec_core];
            ACC_STATUS: reg_rdata = stat_word;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
// Property checker for irq_router_top, attached by bind below.
// Observes ports plus the enable and synchronized-status vectors.
module irq_router_chk #(
    parameter int N_CORES = 2,
    parameter int N_WORDS = 4,
    parameter int ADDR_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_WORDS*32-1:0]        irq_src,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic                         reg_we,
    input logic [31:0]                  reg_rdata,
    input logic [N_CORES-1:0]           core_irq,
    input logic [N_CORES*N_WORDS*32-1:0] en_all,
    input logic [N_WORDS*32-1:0]        stat_q
);
    localparam int N_SRC = N_WORDS * 32;
    localparam int unsigned BANK_WORDS  = 2 * N_WORDS;
    localparam int unsigned TOTAL_WORDS = N_CORES * BANK_WORDS;

    logic [1:0] cyc_q;
    logic       in_win;
    logic       is_stat;

    // Cycles since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= 2'd0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    // Independent view of the address window
    always_comb begin
        int unsigned idx_u;
        idx_u   = 32'(reg_addr) >> 2;
        in_win  = idx_u < TOTAL_WORDS;
        is_stat = in_win && ((idx_u % BANK_WORDS) >= N_WORDS);
    end

    // R4: status equals the source two edges earlier
    a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (stat_q == $past(irq_src, 2)));

    // R8: status-offset writes leave all enables untouched
    a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && is_stat) |=> $stable(en_all));

    // R9: writes outside the window leave all enables untouched
    a_r9_outside_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !in_win) |=> $stable(en_all));

    // R9: reads outside the window return zero
    a_r9_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (reg_rdata == '0));

    for (genvar c = 0; c < N_CORES; c++) begin : g_core_chk
        // R3: enables are clear in the first cycle after reset
        a_r3_enables_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (en_all[c*N_SRC +: N_SRC] == '0));

        // R5: an output high needs an enable bit set one cycle earlier
        a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            core_irq[c] |-> $past(|en_all[c*N_SRC +: N_SRC]));

        // R5: with no enable set, the output is low next cycle
        a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[c*N_SRC +: N_SRC] == '0) |=> !core_irq[c]);
    end
endmodule

bind irq_router_top irq_router_chk #(
    .N_CORES (N_CORES),
    .N_WORDS (N_WORDS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .core_irq  (core_irq),
    .en_all    (en_all),
    .stat_q    (stat_q)
);

// File: tb/irq_router_top_tb.sv
module irq_router_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src = '0;
    logic [7:0]   addr = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [1:0]   irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_router_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (src),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .core_irq  (irq)
    );

    typedef struct packed {
        logic [127:0] s;
        logic [127:0] e0;
        logic [127:0] e1;
        logic [1:0]   exp_irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{128'h0, {128{1'b1}}, {128{1'b1}}, 2'b00},
        '{128'(1) << 0, 128'(1) << 0, 128'h0, 2'b01},
        '{128'(1) << 127, 128'(1) << 126, 128'(1) << 127, 2'b10},
        '{(128'(1) << 40) | (128'(1) << 70), 128'(1) << 70, 128'(1) << 40, 2'b11},
        '{{128{1'b1}}, 128'h0, 128'h0, 2'b00},
        '{(128'(1) << 31) | (128'(1) << 32), 128'(1) << 32, 128'(1) << 31, 2'b11},
        '{128'(1) << 96, 128'(1) << 95, 128'(1) << 97, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic load_en(input logic [127:0] e0, input logic [127:0] e1);
        for (int w = 0; w < 4; w++) begin
            wr(8'(w * 4), e0[(3 - w) * 32 +: 32]);
            wr(8'(8'h20 + w * 4), e1[(3 - w) * 32 +: 32]);
        end
    endtask

    task automatic check_en(input string tag, input logic [127:0] e0, input logic [127:0] e1);
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            rd(8'(w * 4), d);
            chk(tag, d, e0[(3 - w) * 32 +: 32]);
            rd(8'(8'h20 + w * 4), d);
            chk(tag, d, e1[(3 - w) * 32 +: 32]);
        end
    endtask

    task automatic check_stat(input string tag, input logic [127:0] s);
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            rd(8'(8'h10 + w * 4), d);
            chk(tag, d, s[(3 - w) * 32 +: 32]);
            rd(8'(8'h30 + w * 4), d);
            chk(tag, d, s[(3 - w) * 32 +: 32]);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [127:0] e0_keep, e1_keep;
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk("R3 irq after reset", 32'(irq), 32'h0);
        check_en("R3 enables after reset", 128'h0, 128'h0);

        // Table walk: R1 R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src = VECS[v].s;
            load_en(VECS[v].e0, VECS[v].e1);
            wait_cyc(4);
            chk($sformatf("R5 R7 irq vec %0d", v), 32'(irq), 32'(VECS[v].exp_irq));
            check_stat($sformatf("R1 R2 status vec %0d", v), VECS[v].s);
            check_en($sformatf("R6 enable readback vec %0d", v), VECS[v].e0, VECS[v].e1);
        end

        // R7: a write to core 0 only leaves core 1 intact
        load_en(128'h0, 128'h0);
        wr(8'h0C, 32'h0000_00F0);
        check_en("R7 bank independence", 128'h0000_00F0, 128'h0);

        // R10: enable write latency
        @(negedge clk);
        src = 128'(1) << 5;
        load_en(128'h0, 128'h0);
        wait_cyc(4);
        chk("R10 irq before write", 32'(irq), 32'h0);
        wr(8'h0C, 32'h0000_0020);
        chk("R10 irq at capture edge", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R10 irq one edge later", 32'(irq), 32'h1);

        // R7: same source enabled in both cores rises together
        load_en(128'h0, 128'h0);
        wait_cyc(2);
        @(negedge clk);
        src = 128'h0;
        load_en(128'(1) << 64, 128'(1) << 64);
        wait_cyc(3);
        chk("R7 both low before source", 32'(irq), 32'h0);
        @(negedge clk);
        src = 128'(1) << 64;
        wait_cyc(3);
        chk("R7 both cores together", 32'(irq), 32'h3);

        // R4 R11: synchronizer latency seen through a status read
        @(negedge clk);
        src = 128'h0;
        addr = 8'h1C;
        wait_cyc(3);
        src = 128'(1) << 8;
        #1 chk("R11 status before edge", rdata, 32'h0);
        @(negedge clk);
        #1 chk("R4 status after one edge", rdata, 32'h0);
        @(negedge clk);
        #1 chk("R4 status after two edges", rdata, 32'h0000_0100);

        // R8: writes to status offsets are ignored
        e0_keep = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        e1_keep = 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_0F0F_F0F0;
        @(negedge clk);
        src = 128'h0;
        load_en(e0_keep, e1_keep);
        wait_cyc(3);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        check_en("R8 enables after status write", e0_keep, e1_keep);
        check_stat("R8 status after status write", 128'h0);

        // R9: outside the window
        rd(8'h40, d);
        chk("R9 read 0x40", d, 32'h0);
        rd(8'hFC, d);
        chk("R9 read 0xFC", d, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'hCC, 32'hFFFF_FFFF);
        check_en("R9 enables after outside write", e0_keep, e1_keep);

        // R1: low address bits ignored
        wr(8'h23, 32'hCAFE_F00D);
        rd(8'h20, d);
        chk("R1 low bits ignored", d, 32'hCAFE_F00D);

        // R3: reset mid-run clears enables and outputs
        @(negedge clk);
        src = {128{1'b1}};
        load_en({128{1'b1}}, {128{1'b1}});
        wait_cyc(4);
        chk("R5 all on", 32'(irq), 32'h3);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        chk("R3 irq after second reset", 32'(irq), 32'h0);
        check_en("R3 enables after second reset", 128'h0, 128'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule